// File: doc/BRIEF.md
# Single-Sector Instruction Fetch Cache

This block lets a small processor run code straight from a memory card that can only be read one 512-byte sector at a time. It sits between the processor's memory port and a byte-serial sector reader. Locally it keeps exactly one sector, together with the sector number it came from and a valid flag. Each fetch address is split into a sector number (the address shifted right by 9) and a byte offset. When the sector number matches the one held, the word is returned on the next clock with a ready pulse. When it does not match, the processor is stalled. The block then asks the reader for the new sector, stores the bytes as they stream in, and completes the original fetch once the whole sector is present.

A three-state controller drives the refill. In `ST_IDLE` it waits for a fetch. A miss moves it to `ST_START`. There it pulses the reader's start line once, when the reader is not busy, and it stays in `ST_START` until the reader raises busy. It then moves to `ST_READ`, where every byte strobe writes one byte at the position given by a byte counter. The 512th byte moves it back to `ST_IDLE`. In that state a pending-completion flag replays the latched fetch and raises ready. The processor cannot write to the card. A write request is acknowledged and otherwise ignored.

Top module: `sector_fetch_cache`

## Requirements
- R1: The store holds exactly one 512-byte sector. A read word is the four bytes at the word-aligned offset (address bits 8:2 times 4), little-endian: the byte at the lowest offset sits in bits 7:0 and the byte at offset+3 sits in bits 31:24.
- R2: A read whose address bits 31:9 equal the held sector tag, with the valid flag set, raises `cpu_ready` for exactly one cycle, on the clock after the request is accepted. No `rd_start` is issued.
- R3: Reset clears the valid flag, so the first read after reset is a miss. Any miss issues `rd_start` with `rd_sector` equal to address bits 31:9.
- R4: `rd_start` is high for a single cycle, only while `rd_busy` is low, and exactly once per miss.
- R5: The controller goes `ST_IDLE` to `ST_START` on a miss, `ST_START` to `ST_READ` when `rd_busy` is seen after the pulse, and `ST_READ` to `ST_IDLE` on the 512th byte strobe.
- R6: The k-th byte received during a refill (k counted from 0) is stored at sector offset k.
- R7: `cpu_ready` stays low for the whole refill. The stalled read completes with one ready pulse, carrying the word for the missed address, only after all 512 bytes have arrived.
- R8: The address is captured at the miss. Changes on `cpu_addr` during the refill alter neither `rd_sector` nor the returned word.
- R9: A write request (`cpu_we` high) gets a ready pulse on the next clock. It starts no refill and leaves the stored sector unchanged.
- R10: Byte strobes arriving outside `ST_READ` do not change the stored sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | Request is a write (acknowledged, ignored) |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| rd_start | output | 1 | One-cycle sector read command to the reader |
| rd_sector | output | 23 | Sector number to read |
| rd_busy | input | 1 | Reader is working on a sector |
| rd_byte_vld | input | 1 | A sector byte is present on `rd_byte` |
| rd_byte | input | 8 | Sector byte data |

## Verification
The bench aims at the edges of the sector: the last word of one sector and the first word of the next. A tag taken from the wrong bits would turn one of these into a spurious hit or a spurious miss. Every word of a filled sector is compared against arithmetic byte patterns. A counter that skipped or repeated a byte, or a reversed byte lane, would show up as a wrong word. The bench also jumbles the address bus during a refill and fires stray byte strobes while the controller is idle. A design that failed to latch the address would fetch the wrong sector or return the wrong word, and one that accepted stray strobes would corrupt the stored bytes. Write requests are checked for an immediate acknowledge with no refill, since a design that stalled on them would hang the processor.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_READ  = 2'd2
    } sfc_state_e;
endpackage

// File: rtl/sfc_bank.sv
// One byte lane of the sector store: synchronous write, registered read.
module sfc_bank #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/sfc_store.sv
// Sector store split into byte lanes so a whole word reads in one cycle.
module sfc_store #(
    parameter int SECTOR_BYTES = 512,
    parameter int LANES        = 4
) (
    input  logic                            clk,
    input  logic                            we,
    input  logic [$clog2(SECTOR_BYTES)-1:0] wofs,
    input  logic [7:0]                      wdata,
    input  logic                            re,
    input  logic [$clog2(SECTOR_BYTES)-$clog2(LANES)-1:0] ridx,
    output logic [8*LANES-1:0]              rdata
);
    localparam int OFS_W  = $clog2(SECTOR_BYTES);
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = OFS_W - LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = we && (wofs[LANE_W-1:0] == LANE_W'(g));

        sfc_bank #(.IDX_W(IDX_W)) u_bank (
            .clk   (clk),
            .we    (lane_we),
            .waddr (wofs[OFS_W-1:LANE_W]),
            .wdata (wdata),
            .re    (re),
            .raddr (ridx),
            .rdata (rdata[8*g +: 8])
        );
    end
endmodule

// File: rtl/sfc_ctrl.sv
// Tag check and three-state refill controller.
module sfc_ctrl
    import sfc_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int SECTOR_BYTES = 512,
    parameter int LANES        = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cpu_req,
    input  logic                                    cpu_we,
    input  logic [ADDR_W-$clog2(LANES)-1:0]         cpu_wa,
    output logic                                    cpu_ready,
    output logic                                    rd_start,
    output logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0]  rd_sector,
    input  logic                                    rd_busy,
    input  logic                                    rd_byte_vld,
    output logic                                    st_we,
    output logic [$clog2(SECTOR_BYTES)-1:0]         st_wofs,
    output logic                                    st_re,
    output logic [$clog2(SECTOR_BYTES)-$clog2(LANES)-1:0] st_ridx,
    output sfc_state_e                              state
);
    localparam int OFS_W  = $clog2(SECTOR_BYTES);
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = OFS_W - LANE_W;
    localparam int TAG_W  = ADDR_W - OFS_W;
    localparam int WA_W   = ADDR_W - LANE_W;
    localparam logic [OFS_W-1:0] LAST = OFS_W'(SECTOR_BYTES - 1);

    sfc_state_e         state_q, state_d;
    logic [TAG_W-1:0]   tag_q;
    logic               valid_q;
    logic [WA_W-1:0]    wa_q;
    logic [OFS_W-1:0]   cnt_q;
    logic               issued_q;
    logic               pend_q;
    logic               ready_q;

    logic hit, serve, miss, fill_done;

    assign hit = valid_q && (cpu_wa[WA_W-1:IDX_W] == tag_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        rd_start  = 1'b0;
        st_we     = 1'b0;
        st_re     = 1'b0;
        st_ridx   = wa_q[IDX_W-1:0];
        serve     = 1'b0;
        miss      = 1'b0;
        fill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q) begin
                    st_re = 1'b1;
                    serve = 1'b1;
                end else if (cpu_req && !ready_q) begin
                    if (cpu_we) begin
                        serve = 1'b1;
                    end else if (hit) begin
                        st_re   = 1'b1;
                        st_ridx = cpu_wa[IDX_W-1:0];
                        serve   = 1'b1;
                    end else begin
                        miss    = 1'b1;
                        state_d = ST_START;
                    end
                end
            end
            ST_START: begin
                rd_start = !issued_q && !rd_busy;
                if (issued_q && rd_busy) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (rd_byte_vld) begin
                    st_we = 1'b1;
                    if (cnt_q == LAST) begin
                        fill_done = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Tag, counter and handshake registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            valid_q  <= 1'b0;
            wa_q     <= '0;
            cnt_q    <= '0;
            issued_q <= 1'b0;
            pend_q   <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            ready_q <= serve;
            if (serve) begin
                pend_q <= 1'b0;
            end
            if (miss) begin
                wa_q     <= cpu_wa;
                valid_q  <= 1'b0;
                issued_q <= 1'b0;
                cnt_q    <= '0;
            end
            if (rd_start) begin
                issued_q <= 1'b1;
            end
            if (st_we) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (fill_done) begin
                tag_q   <= wa_q[WA_W-1:IDX_W];
                valid_q <= 1'b1;
                pend_q  <= 1'b1;
            end
        end
    end

    assign cpu_ready = ready_q;
    assign rd_sector = wa_q[WA_W-1:IDX_W];
    assign st_wofs   = cnt_q;
    assign state     = state_q;
endmodule

// File: rtl/sector_fetch_cache.sv
// One-sector read-only fetch cache in front of a byte-serial sector reader.
module sector_fetch_cache
    import sfc_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int SECTOR_BYTES = 512,
    parameter int LANES        = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cpu_req,
    input  logic                                   cpu_we,
    input  logic [ADDR_W-1:0]                      cpu_addr,
    output logic [8*LANES-1:0]                     cpu_rdata,
    output logic                                   cpu_ready,
    output logic                                   rd_start,
    output logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] rd_sector,
    input  logic                                   rd_busy,
    input  logic                                   rd_byte_vld,
    input  logic [7:0]                             rd_byte
);
    localparam int OFS_W  = $clog2(SECTOR_BYTES);
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = OFS_W - LANE_W;
    localparam int TAG_W  = ADDR_W - OFS_W;

    logic              st_we, st_re;
    logic [OFS_W-1:0]  st_wofs;
    logic [IDX_W-1:0]  st_ridx;
    sfc_state_e        fsm_state;

    sfc_ctrl #(
        .ADDR_W       (ADDR_W),
        .SECTOR_BYTES (SECTOR_BYTES),
        .LANES        (LANES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_wa      (cpu_addr[ADDR_W-1:LANE_W]),
        .cpu_ready   (cpu_ready),
        .rd_start    (rd_start),
        .rd_sector   (rd_sector),
        .rd_busy     (rd_busy),
        .rd_byte_vld (rd_byte_vld),
        .st_we       (st_we),
        .st_wofs     (st_wofs),
        .st_re       (st_re),
        .st_ridx     (st_ridx),
        .state       (fsm_state)
    );

    sfc_store #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .LANES        (LANES)
    ) u_store (
        .clk   (clk),
        .we    (st_we),
        .wofs  (st_wofs),
        .wdata (rd_byte),
        .re    (st_re),
        .ridx  (st_ridx),
        .rdata (cpu_rdata)
    );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker
    import sfc_pkg::*;
#(
    parameter int TAG_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             rd_start,
    input logic             rd_busy,
    input logic [TAG_W-1:0] rd_sector,
    input sfc_state_e       state
);
    // R4: the read command is a single-cycle pulse
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    // R4: the read command is never issued to a busy reader
    p_start_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> !rd_busy);

    // R2: completion is a one-cycle pulse
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R7: no completion while a refill is in progress
    p_stall_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !cpu_ready);

    // R8: the requested sector holds still through a refill
    p_sector_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(rd_sector));

    // R5: the command pulse comes only from the start state
    p_start_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (state == ST_START));

    // R5: the read state exits only back to idle
    p_read_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |=> (state == ST_READ || state == ST_IDLE));
endmodule

bind sector_fetch_cache sfc_checker #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .rd_start  (rd_start),
    .rd_busy   (rd_busy),
    .rd_sector (rd_sector),
    .state     (fsm_state)
);

// File: tb/sector_fetch_cache_test.sv
`timescale 1ns/1ps
module sector_fetch_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        rd_start;
    logic [22:0] rd_sector;
    logic        rd_busy = 1'b0;
    logic        rdr_vld = 1'b0;
    logic        stray_vld = 1'b0;
    logic        rd_byte_vld;
    logic [7:0]  rd_byte = '0;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int bytes_sent = 0;
    int last_sector = -1;
    bit done = 1'b0;

    assign rd_byte_vld = rdr_vld | stray_vld;

    always #4 clk = ~clk;

    sector_fetch_cache uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_rdata   (cpu_rdata),
        .cpu_ready   (cpu_ready),
        .rd_start    (rd_start),
        .rd_sector   (rd_sector),
        .rd_busy     (rd_busy),
        .rd_byte_vld (rd_byte_vld),
        .rd_byte     (rd_byte)
    );

    function automatic logic [7:0] fb(int s, int k);
        return 8'(s * 29 + k * 13 + (k >> 8) * 5 + 3);
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] a);
        int s = int'(a >> 9);
        int o = int'(a[8:0]) & ~3;
        return {fb(s, o + 3), fb(s, o + 2), fb(s, o + 1), fb(s, o)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Sector reader model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_start) begin
                starts++;
                chk(!rd_busy, "R4", "start while busy", 32'(rd_busy), 0);
                last_sector = int'(rd_sector);
                bytes_sent = 0;
                @(negedge clk);
                @(negedge clk);
                rd_busy = 1'b1;
                @(negedge clk);
                for (int k = 0; k < 512; k++) begin
                    rd_byte = fb(last_sector, k);
                    rdr_vld = 1'b1;
                    @(negedge clk);
                    rdr_vld = 1'b0;
                    bytes_sent++;
                    @(negedge clk);
                end
                rd_busy = 1'b0;
            end
        end
    end

    task automatic cpu_access(input logic [31:0] a, input bit we, input bit scramble,
                              output logic [31:0] d, output int lat);
        @(negedge clk);
        cpu_addr = a;
        cpu_we = we;
        cpu_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (scramble) cpu_addr = a ^ 32'h5A5A_0000 ^ (32'(lat) * 32'h104);
        end while (!cpu_ready && lat < 5000);
        d = cpu_rdata;
        cpu_req = 1'b0;
        cpu_we = 1'b0;
    endtask

    task automatic miss_read(input logic [31:0] a, input bit scramble, string tag);
        logic [31:0] d;
        int lat;
        int s0 = starts;
        cpu_access(a, 1'b0, scramble, d, lat);
        chk(starts == s0 + 1, "R4", {tag, " one start per miss"}, 32'(starts - s0), 1);
        chk(last_sector == int'(a >> 9), "R3", {tag, " sector number"}, 32'(last_sector), a >> 9);
        chk(bytes_sent == 512, "R7", {tag, " ready only after full fill"}, 32'(bytes_sent), 512);
        chk(lat > 1024, "R5", {tag, " refill duration"}, 32'(lat), 1025);
        chk(d == exp_word(a), "R8", {tag, " data for missed address"}, d, exp_word(a));
    endtask

    task automatic hit_read(input logic [31:0] a, string req);
        logic [31:0] d;
        int lat;
        int s0 = starts;
        cpu_access(a, 1'b0, 1'b0, d, lat);
        chk(lat == 1, "R2", "hit latency", 32'(lat), 1);
        chk(starts == s0, "R2", "no start on hit", 32'(starts - s0), 0);
        chk(d == exp_word(a), req, "hit data", d, exp_word(a));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lat;
        int s0;

        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R2", "ready low in reset", 32'(cpu_ready), 0);
        chk(rd_start == 1'b0, "R4", "start low in reset", 32'(rd_start), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: first read after reset misses
        miss_read(32'h0000_0604, 1'b0, "R3 first");

        // R1 R6: sweep every word of sector 3
        for (int w = 0; w < 128; w++) begin
            hit_read(32'h0000_0600 + 32'(w * 4), "R6");
        end
        // R1: unaligned low bits select the same aligned word
        hit_read(32'h0000_07FF, "R1");

        // R8: boundary miss with the address bus jumbled during refill
        miss_read(32'h0000_05FC, 1'b1, "R8 boundary");
        hit_read(32'h0000_0400, "R1");
        hit_read(32'h0000_05FC, "R1");

        // R3: only one line, so returning to sector 3 misses again
        miss_read(32'h0000_0604, 1'b0, "R3 return");

        // R3: top sector of the address space
        miss_read(32'hFFFF_FFFC, 1'b0, "R3 top");

        // R9: writes acknowledged, no refill, contents unchanged
        s0 = starts;
        cpu_access(32'hFFFF_FF00, 1'b1, 1'b0, d, lat);
        chk(lat == 1, "R9", "write ack latency (hit)", 32'(lat), 1);
        cpu_access(32'h0000_0000, 1'b1, 1'b0, d, lat);
        chk(lat == 1, "R9", "write ack latency (miss)", 32'(lat), 1);
        chk(starts == s0, "R9", "no refill on write", 32'(starts - s0), 0);
        hit_read(32'hFFFF_FF00, "R9");
        hit_read(32'hFFFF_FFFC, "R9");

        // R10: stray byte strobes while idle
        @(negedge clk);
        rd_byte = 8'hEE;
        stray_vld = 1'b1;
        repeat (6) @(negedge clk);
        stray_vld = 1'b0;
        for (int w = 0; w < 4; w++) begin
            hit_read(32'hFFFF_FE00 + 32'(w * 4), "R10");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule